// File: doc/BRIEF.md
# Dual-Bank Fractional-N Feedback Divider

This block sits in the feedback path of a phase-locked loop. It counts cycles of the VCO-rate clock and produces one feedback pulse for each divided cycle, which goes to the phase detector. Each divided cycle lasts either the integer part N of the programmed ratio or N+1 clocks. A 24-bit first-order phase accumulator picks between the two, so the long-run average ratio is N + F/2^24. For example, N = 92 with F = 13,578,884 averages about 92.809. A modulus-control output marks every cycle that divides by N+1, for use by a dual-modulus prescaler.

Two programming banks each hold a 9-bit integer and a 24-bit fraction. The fraction is written as a 16-bit upper word and an 8-bit lower word. The `bank_sel` input picks the active bank: bank 1 when low, bank 2 when high. A new ratio only takes effect where one divided cycle ends and the next begins, whether it comes from a register write or a bank switch. The divided cycles therefore never come out truncated or stretched. Ratios outside 15..511 are forced to the nearest legal value, and `clamp_flag` reports this.

Top module: `fracn_div_ctrl`

## Requirements
- R1: After reset, both banks hold integer 15 and fraction 0, the accumulator is 0, and `mod_ctl` and `clamp_flag` are low. The first `fb_pulse` is high in the 15th clock period after reset is released.
- R2: `fb_pulse` is high for exactly one clock, in the last clock of each divided cycle. A divided cycle lasts N or N+1 clocks of the effective ratio.
- R3: At each cycle boundary, the effective fraction is added modulo 2^24 to a 24-bit accumulator. On carry-out, the next divided cycle is N+1 clocks and `mod_ctl` is high throughout it. Otherwise the cycle is N clocks and `mod_ctl` is low throughout it. Over 256 cycles with fraction 0x400000, exactly 64 cycles are N+1.
- R4: A write with `wr_en` high stores data at the clock edge. `wr_addr[2]` selects the bank (0 = bank 1, 1 = bank 2). `wr_addr[1:0]` selects the field: 0 = integer from `wr_data[8:0]`, 1 = fraction bits 23..8 from `wr_data[15:0]`, 2 = fraction bits 7..0 from `wr_data[7:0]`. Field code 3 changes nothing, and writing one fraction word leaves the other word unchanged.
- R5: With `bank_sel` low, bank 1 sets the ratio. With `bank_sel` high, bank 2 sets it.
- R6: The ratio, `mod_ctl` and `clamp_flag` change only at the clock edge that follows an `fb_pulse`. A cycle already in progress keeps the length it started with.
- R7: An integer below 15 (any fraction) is used as 15.0, and `clamp_flag` is high for the divided cycles that use the clamped ratio.
- R8: Integer 511 with a nonzero fraction is used as 511.0, with `clamp_flag` high. Exactly 15.0 and exactly 511.0 are used unchanged, with `clamp_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-rate clock being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address: bank in bit 2, field in bits 1..0 |
| wr_data | input | 16 | Register write data |
| bank_sel | input | 1 | Bank select: low = bank 1, high = bank 2 |
| mod_ctl | output | 1 | High during each divided cycle of N+1 clocks |
| fb_pulse | output | 1 | One-clock pulse in the last clock of every divided cycle |
| clamp_flag | output | 1 | High while the active ratio is clamped to 15 or 511 |

## Verification
A write or bank switch becomes visible to the ratio selection one edge after it is driven. It only changes the output at the edge after the next `fb_pulse`, and from then on the new cycle length, `mod_ctl` and `clamp_flag` all hold until the following pulse. The bench therefore drives writes and bank switches only when `fb_pulse` is low. Its reference model advances only at each negative edge where the pulse is seen, using the register contents it has mirrored by then. Each measured cycle length, the `mod_ctl` level over the whole cycle and the `clamp_flag` level are compared against the prediction made one pulse earlier.

// File: rtl/fnd_pkg.sv
// Package: shared widths, defaults and the ratio type for the
// fractional-N feedback divider. Assumes one integer and one fraction
// field per bank, the fraction split into an upper and a lower word.
package fnd_pkg;
    localparam int INT_W     = 9;
    localparam int FRAC_W    = 24;
    localparam int HI_W      = 16;
    localparam int LO_W      = FRAC_W - HI_W;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 16;
    localparam int NUM_BANKS = 2;
    localparam int INT_MIN   = 15;
    localparam int INT_MAX   = (1 << INT_W) - 1;
    localparam int DEF_INT   = 15;
    localparam int CNT_W     = INT_W + 1;

    // Field codes carried in the low address bits
    localparam logic [1:0] FLD_INT = 2'd0;
    localparam logic [1:0] FLD_HI  = 2'd1;
    localparam logic [1:0] FLD_LO  = 2'd2;

    typedef struct packed {
        logic [INT_W-1:0]  int_part;
        logic [FRAC_W-1:0] frac;
    } ratio_t;
endpackage

// File: rtl/fnd_bank_regs.sv
// Module: two programming banks, each one integer plus a fraction kept
// as an upper and a lower word. Assumes the top address bit names the
// bank and the two low bits name the field; field code 3 is ignored.
module fnd_bank_regs
    import fnd_pkg::*;
#(
    parameter int P_INT_W   = INT_W,
    parameter int P_HI_W    = HI_W,
    parameter int P_LO_W    = LO_W,
    parameter int P_ADDR_W  = ADDR_W,
    parameter int P_DATA_W  = DATA_W,
    parameter int P_BANKS   = NUM_BANKS,
    parameter int P_DEF_INT = DEF_INT
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_ADDR_W-1:0] wr_addr,
    input  logic [P_DATA_W-1:0] wr_data,
    output ratio_t [P_BANKS-1:0] banks_q
);
    localparam int BANK_BIT = P_ADDR_W - 1;

    logic [1:0] fld;
    assign fld = wr_addr[1:0];

    for (genvar b = 0; b < P_BANKS; b++) begin : g_bank
        logic [P_INT_W-1:0] int_q;
        logic [P_HI_W-1:0]  hi_q;
        logic [P_LO_W-1:0]  lo_q;
        logic               hit;

        assign hit = wr_en && (wr_addr[BANK_BIT] == b[0]);

        // Purpose: hold and update this bank's three fields
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                int_q <= P_INT_W'(P_DEF_INT);
                hi_q  <= '0;
                lo_q  <= '0;
            end else if (hit) begin
                case (fld)
                    FLD_INT: int_q <= wr_data[P_INT_W-1:0];
                    FLD_HI:  hi_q  <= wr_data[P_HI_W-1:0];
                    FLD_LO:  lo_q  <= wr_data[P_LO_W-1:0];
                    default: ;
                endcase
            end
        end

        assign banks_q[b].int_part = int_q;
        assign banks_q[b].frac     = {hi_q, lo_q};
    end
endmodule

// File: rtl/fnd_ratio_guard.sv
// Module: picks the bank named by the select input and forces the ratio
// into the legal range. Below the minimum integer gives MIN.0; anything
// above MAX.0 gives MAX.0. Purely combinational.
module fnd_ratio_guard
    import fnd_pkg::*;
#(
    parameter int P_BANKS   = NUM_BANKS,
    parameter int P_INT_MIN = INT_MIN,
    parameter int P_INT_MAX = INT_MAX
) (
    input  ratio_t [P_BANKS-1:0] banks_q,
    input  logic                 bank_sel,
    output ratio_t               eff,
    output logic                 clamp
);
    ratio_t sel;
    logic   too_low;
    logic   too_high;

    assign sel      = banks_q[bank_sel];
    assign too_low  = sel.int_part < INT_W'(P_INT_MIN);
    assign too_high = (sel.int_part == INT_W'(P_INT_MAX)) && (|sel.frac);

    // Purpose: produce the clamped effective ratio and the clamp status
    always_comb begin
        eff   = sel;
        clamp = 1'b0;
        if (too_low) begin
            eff.int_part = INT_W'(P_INT_MIN);
            eff.frac     = '0;
            clamp        = 1'b1;
        end else if (too_high) begin
            eff.int_part = INT_W'(P_INT_MAX);
            eff.frac     = '0;
            clamp        = 1'b1;
        end
    end
endmodule

// File: rtl/fnd_phase_acc.sv
// Module: first-order phase accumulator. On each step it adds the
// fraction modulo 2^FRAC_W; the carry of that sum is offered
// combinationally so the counter can register it at the same edge.
module fnd_phase_acc
    import fnd_pkg::*;
#(
    parameter int P_FRAC_W = FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step,
    input  logic [P_FRAC_W-1:0] frac,
    output logic                carry_nxt
);
    logic [P_FRAC_W-1:0] acc_q;
    logic [P_FRAC_W:0]   sum;

    assign sum       = {1'b0, acc_q} + {1'b0, frac};
    assign carry_nxt = sum[P_FRAC_W];

    // Purpose: advance the accumulated phase once per divided cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[P_FRAC_W-1:0];
        end
    end
endmodule

// File: rtl/fnd_mod_counter.sv
// Module: down-counter that sets the length of each divided cycle.
// When it reaches zero the cycle ends; at that edge it reloads with
// N + carry - 1 and latches the carry as the modulus control.
module fnd_mod_counter
    import fnd_pkg::*;
#(
    parameter int P_INT_W   = INT_W,
    parameter int P_CNT_W   = CNT_W,
    parameter int P_DEF_INT = DEF_INT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_INT_W-1:0] int_eff,
    input  logic               carry,
    output logic               boundary,
    output logic               mod_q
);
    logic [P_CNT_W-1:0] cnt_q;
    logic [P_CNT_W-1:0] reload;

    assign boundary = (cnt_q == '0);
    assign reload   = P_CNT_W'(int_eff) + P_CNT_W'(carry) - P_CNT_W'(1);

    // Purpose: count down the current cycle and reload at its end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= P_CNT_W'(P_DEF_INT - 1);
            mod_q <= 1'b0;
        end else if (boundary) begin
            cnt_q <= reload;
            mod_q <= carry;
        end else begin
            cnt_q <= cnt_q - P_CNT_W'(1);
        end
    end
endmodule

// File: rtl/fracn_div_ctrl.sv
// Module: top of the dual-bank fractional-N feedback divider. Ties the
// banks, range guard, accumulator and counter together. All ratio
// changes are sampled at the end of a divided cycle only.
module fracn_div_ctrl
    import fnd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bank_sel,
    output logic              mod_ctl,
    output logic              fb_pulse,
    output logic              clamp_flag
);
    ratio_t [NUM_BANKS-1:0] banks_q;
    ratio_t                 eff;
    logic                   clamp;
    logic                   carry_nxt;
    logic                   boundary;
    logic                   clamp_q;

    fnd_bank_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .banks_q (banks_q)
    );

    fnd_ratio_guard u_guard (
        .banks_q  (banks_q),
        .bank_sel (bank_sel),
        .eff      (eff),
        .clamp    (clamp)
    );

    fnd_phase_acc u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (boundary),
        .frac      (eff.frac),
        .carry_nxt (carry_nxt)
    );

    fnd_mod_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .int_eff  (eff.int_part),
        .carry    (carry_nxt),
        .boundary (boundary),
        .mod_q    (mod_ctl)
    );

    // Purpose: hold the clamp status for the cycle that uses the ratio
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clamp_q <= 1'b0;
        end else if (boundary) begin
            clamp_q <= clamp;
        end
    end

    assign fb_pulse   = boundary;
    assign clamp_flag = clamp_q;
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
// Module: property checker for the feedback divider, bound to the top.
// Keeps its own count of clocks since the last pulse to bound the
// divided-cycle length without deep history.
module fracn_div_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic fb_pulse,
    input logic mod_ctl,
    input logic clamp_flag
);
    logic [11:0] gap_q;

    // Purpose: clocks elapsed since reset or since the last pulse
    always_ff @(posedge clk) begin
        if (!rst_n || fb_pulse) begin
            gap_q <= '0;
        end else if (gap_q != 12'hFFF) begin
            gap_q <= gap_q + 12'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!mod_ctl && !clamp_flag && !fb_pulse)); // R1
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fb_pulse |=> !fb_pulse); // R2
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n) fb_pulse |-> (gap_q >= 12'd14)); // R2
    AST_GAP_MAX: assert property (@(posedge clk) disable iff (!rst_n) (gap_q >= 12'd511) |-> fb_pulse); // R2
    AST_MOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fb_pulse |=> $stable(mod_ctl)); // R6
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !fb_pulse |=> $stable(clamp_flag)); // R6
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fb_pulse   (fb_pulse),
    .mod_ctl    (mod_ctl),
    .clamp_flag (clamp_flag)
);

// File: tb/fracn_div_ctrl_bench.sv
// Directed bench for the feedback divider. A negedge monitor predicts
// every divided cycle from a mirror of the registers; each scenario task
// also checks its own targeted result.
module fracn_div_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        bank_sel = 1'b0;
    logic        mod_ctl, fb_pulse, clamp_flag;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // mirror of the register banks
    logic [8:0]  m_int [2];
    logic [15:0] m_hi  [2];
    logic [7:0]  m_lo  [2];

    // reference model state
    logic [23:0] r_acc = '0;
    int          exp_len = 15;
    logic        exp_mod = 1'b0;
    logic        exp_flag = 1'b0;
    bit          mon_on = 0;
    int          cyc = 0;
    bit          mod_bad = 0;
    int          last_len = 0;
    int          pulses = 0;
    int          mods = 0;
    string       cur_req = "R1";

    fracn_div_ctrl u_fracn_div_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bank_sel(bank_sel), .mod_ctl(mod_ctl),
        .fb_pulse(fb_pulse), .clamp_flag(clamp_flag)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // predict the next cycle from the mirror and the current select
    task automatic model_step();
        logic [8:0]  i;
        logic [23:0] f;
        logic        fl;
        logic [24:0] s;
        i  = m_int[bank_sel];
        f  = {m_hi[bank_sel], m_lo[bank_sel]};
        fl = 1'b0;
        if (i < 9'd15) begin
            i = 9'd15; f = '0; fl = 1'b1;
        end else if (i == 9'd511 && f != 0) begin
            i = 9'd511; f = '0; fl = 1'b1;
        end
        s        = {1'b0, r_acc} + {1'b0, f};
        r_acc    = s[23:0];
        exp_mod  = s[24];
        exp_len  = int'(i) + int'(s[24]);
        exp_flag = fl;
    endtask

    // Purpose: per-cycle length, modulus and clamp comparison
    always @(negedge clk) begin
        if (mon_on) begin
            cyc++;
            if (mod_ctl !== exp_mod) mod_bad = 1;
            if (fb_pulse) begin
                check(cyc == exp_len, cur_req, "cycle length", cyc, exp_len);
                check(!mod_bad, "R3", "mod_ctl over cycle", int'(mod_ctl), int'(exp_mod));
                check(clamp_flag === exp_flag, cur_req, "clamp_flag", int'(clamp_flag), int'(exp_flag));
                if (exp_mod) mods++;
                pulses++;
                last_len = cyc;
                cyc = 0;
                mod_bad = 0;
                model_step();
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        while (fb_pulse) @(negedge clk);
        #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        case (a[1:0])
            2'd0: m_int[a[2]] = d[8:0];
            2'd1: m_hi[a[2]]  = d;
            2'd2: m_lo[a[2]]  = d[7:0];
            default: ;
        endcase
        @(negedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic set_bank(input logic b);
        @(negedge clk);
        while (fb_pulse) @(negedge clk);
        #1;
        bank_sel = b;
    endtask

    task automatic wait_pulses(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            while (!fb_pulse) @(negedge clk);
        end
        #2;
    endtask

    task automatic t_reset();
        cur_req = "R1";
        @(negedge clk);
        #2;
        check(fb_pulse == 1'b0, "R1", "fb_pulse after reset", int'(fb_pulse), 0);
        check(mod_ctl == 1'b0, "R1", "mod_ctl after reset", int'(mod_ctl), 0);
        check(clamp_flag == 1'b0, "R1", "clamp_flag after reset", int'(clamp_flag), 0);
        wait_pulses(1);
        check(last_len == 15, "R1", "first cycle length", last_len, 15);
        wait_pulses(2);
        check(last_len == 15, "R1", "default ratio", last_len, 15);
    endtask

    task automatic t_integer();
        cur_req = "R2";
        wr(3'd0, 16'd20);
        wait_pulses(4);
        check(last_len == 20, "R2", "integer-only length", last_len, 20);
    endtask

    task automatic t_fraction();
        cur_req = "R3";
        wr(3'd0, 16'd92);
        wr(3'd1, 16'hCF32);
        wr(3'd2, 16'h0084);
        wait_pulses(40);
        check(last_len == 92 || last_len == 93, "R3", "fractional length", last_len, 92);
    endtask

    task automatic t_quarter();
        int m0;
        cur_req = "R3";
        wr(3'd0, 16'd16);
        wr(3'd1, 16'h4000);
        wr(3'd2, 16'h0000);
        wait_pulses(2);
        m0 = mods;
        wait_pulses(256);
        check(mods - m0 == 64, "R3", "long cycles in 256", mods - m0, 64);
    endtask

    task automatic t_regmap();
        cur_req = "R4";
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0080);
        wr(3'd1, 16'h8000);
        wr(3'd3, 16'h0005);
        wr(3'd7, 16'h0005);
        wait_pulses(6);
        check(last_len == 16 || last_len == 17, "R4", "ignored field code", last_len, 16);
    endtask

    task automatic t_bank();
        cur_req = "R5";
        wr(3'd4, 16'd33);
        wr(3'd5, 16'h0000);
        wr(3'd6, 16'h0000);
        set_bank(1'b1);
        wait_pulses(3);
        check(last_len == 33, "R5", "bank 2 length", last_len, 33);
        set_bank(1'b0);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
        wait_pulses(3);
        check(last_len == 16, "R5", "bank 1 length", last_len, 16);
    endtask

    task automatic t_boundary();
        cur_req = "R6";
        wr(3'd0, 16'd20);
        wait_pulses(2);
        wr(3'd0, 16'd40);
        wait_pulses(1);
        check(last_len == 20, "R6", "cycle in progress kept", last_len, 20);
        wait_pulses(1);
        check(last_len == 40, "R6", "new ratio next cycle", last_len, 40);
    endtask

    task automatic t_clamp_lo();
        cur_req = "R7";
        wr(3'd0, 16'd3);
        wr(3'd1, 16'hFFFF);
        wait_pulses(3);
        check(last_len == 15, "R7", "clamped low length", last_len, 15);
        check(clamp_flag == 1'b1, "R7", "clamp flag low side", int'(clamp_flag), 1);
        wr(3'd1, 16'h0000);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'd15);
        wait_pulses(3);
        check(clamp_flag == 1'b0, "R8", "exact 15 not clamped", int'(clamp_flag), 0);
    endtask

    task automatic t_clamp_hi();
        cur_req = "R8";
        wr(3'd0, 16'd511);
        wr(3'd2, 16'h0001);
        wait_pulses(3);
        check(last_len == 511, "R8", "clamped high length", last_len, 511);
        check(clamp_flag == 1'b1, "R8", "clamp flag high side", int'(clamp_flag), 1);
        wr(3'd2, 16'h0000);
        wait_pulses(3);
        check(last_len == 511, "R8", "exact 511 length", last_len, 511);
        check(clamp_flag == 1'b0, "R8", "exact 511 not clamped", int'(clamp_flag), 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int b = 0; b < 2; b++) begin
            m_int[b] = 9'd15; m_hi[b] = '0; m_lo[b] = '0;
        end
        repeat (4) @(posedge clk);
        #5;
        rst_n = 1'b1;
        mon_on = 1;
        t_reset();
        t_integer();
        t_fraction();
        t_quarter();
        t_regmap();
        t_bank();
        t_boundary();
        t_clamp_lo();
        t_clamp_hi();
        summary();
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        summary();
    end
endmodule